// File: doc/BRIEF.md
# Falling-Edge Load/Shift Register with Three-State Stage Outputs

This block is a small register of stages, four by default, that changes state only on the high-to-low transition of its clock. On each falling edge it either captures a parallel word or moves its contents one place toward the last stage, with a serial bit entering the first stage. An active-low clear empties the register at once, without waiting for a clock edge.

The stage values reach the pins through a three-state buffer gated by an output-enable input. The same values are also offered as a plain data word with a separate enable, for flows that cannot carry high impedance inside the chip. A separate chaining output always carries the last stage, so several registers can be cascaded while their stage outputs share a bus. There is no native move toward the first stage. That direction is obtained by feeding each stage output back into the parallel input one place lower and then loading.

Top module: `shreg4_bidir`

## Requirements
- R1: State changes only on a falling clock edge; between falling edges every stage holds its value, whatever the data and mode inputs do.
- R2: While clear_n is low, all stages and cascade_out are 0 at once, without a clock edge, and falling edges do not change them.
- R3: With load_shift high, a falling edge copies par_in into the stages bit for bit: par_in[0] (A) goes to stage 0 (QA), and par_in[WIDTH-1] (D) goes to the last stage (QD).
- R4: With load_shift low, a falling edge puts serial_in into stage 0 and moves each stage i into stage i+1, so the new word is {old[WIDTH-2:0], serial_in}.
- R5: cascade_out always equals the last stage, whatever out_ctrl is; after a load it equals the loaded par_in[WIDTH-1].
- R6: q_oe follows out_ctrl. With out_ctrl high, q_out equals q_data. With out_ctrl low, q_out is high impedance.
- R7: Loading and shifting go on unchanged while out_ctrl is low, and q_data and cascade_out keep tracking the stages.
- R8: A move toward stage 0 is made by loading par_in = {new_bit, q_data[WIDTH-1:1]}, which gives {new_bit, old[WIDTH-1:1]}.
- R9: The first falling edge after clear_n returns high acts as a normal load or shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register acts on its falling edge |
| clear_n | input | 1 | Asynchronous clear, active low |
| load_shift | input | 1 | 1 = parallel load, 0 = shift toward the last stage |
| serial_in | input | 1 | Bit that enters stage 0 on a shift |
| par_in | input | WIDTH | Parallel data; bit 0 feeds stage 0 |
| out_ctrl | input | 1 | Stage output enable, active high |
| q_out | output | WIDTH | Three-state stage outputs |
| q_data | output | WIDTH | Stage values, always driven |
| q_oe | output | 1 | Enable that goes with q_data |
| cascade_out | output | 1 | Last stage, never three-stated |

## Verification
Output disable and register sequencing can fall in the same clock cycle. The bench provokes this by dropping out_ctrl on the same vectors that load or shift. It judges the result through q_data and cascade_out, which must follow the model exactly, while q_oe must read 0. A second overlap is clear against a load request. clear_n is held low across a falling edge while load_shift is high, and the stages must stay at zero. The first edge after release must then load normally.

// File: rtl/shreg4_pkg.sv
package shreg4_pkg;
   typedef enum logic {
      OP_SHIFT = 1'b0,
      OP_LOAD  = 1'b1
   } shreg_op_e;
endpackage

// File: rtl/shreg4_mode_dec.sv
module shreg4_mode_dec
   import shreg4_pkg::*;
(
   input  logic      load_shift,
   output shreg_op_e op
);
   always_comb begin
      if (load_shift) op = OP_LOAD;
      else            op = OP_SHIFT;
   end
endmodule

// File: rtl/shreg4_next.sv
module shreg4_next
   import shreg4_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  shreg_op_e        op,
   input  logic             serial_in,
   input  logic [WIDTH-1:0] par_in,
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic shift_src;
      if (i == 0) begin : g_head
         assign shift_src = serial_in;
      end else begin : g_body
         assign shift_src = cur[i-1];
      end
      assign nxt[i] = (op == OP_LOAD) ? par_in[i] : shift_src;
   end
endmodule

// File: rtl/shreg4_core.sv
module shreg4_core #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             clear_n,
   input  logic [WIDTH-1:0] nxt,
   output logic [WIDTH-1:0] cur
);
   always_ff @(negedge clk or negedge clear_n) begin
      if (!clear_n) cur <= '0;
      else          cur <= nxt;
   end
endmodule

// File: rtl/shreg4_outbuf.sv
module shreg4_outbuf #(
   parameter int WIDTH        = 4,
   parameter bit HAS_TRISTATE = 1'b1
) (
   input  logic [WIDTH-1:0] din,
   input  logic             en,
   output logic [WIDTH-1:0] pad
);
   if (HAS_TRISTATE) begin : g_tri
      assign pad = en ? din : {WIDTH{1'bz}};
   end else begin : g_plain
      assign pad = din;
   end
endmodule

// File: rtl/shreg4_bidir.sv
module shreg4_bidir
   import shreg4_pkg::*;
#(
   parameter int WIDTH        = 4,
   parameter bit HAS_TRISTATE = 1'b1
) (
   input  logic             clk,
   input  logic             clear_n,
   input  logic             load_shift,
   input  logic             serial_in,
   input  logic [WIDTH-1:0] par_in,
   input  logic             out_ctrl,
   output logic [WIDTH-1:0] q_out,
   output logic [WIDTH-1:0] q_data,
   output logic             q_oe,
   output logic             cascade_out
);
   localparam int LAST = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("shreg4_bidir: WIDTH must be at least 2");
   end

   shreg_op_e        op;
   logic [WIDTH-1:0] stage_q;
   logic [WIDTH-1:0] stage_d;

   shreg4_mode_dec u_dec (
      .load_shift (load_shift),
      .op         (op)
   );

   shreg4_next #(.WIDTH(WIDTH)) u_next (
      .op        (op),
      .serial_in (serial_in),
      .par_in    (par_in),
      .cur       (stage_q),
      .nxt       (stage_d)
   );

   shreg4_core #(.WIDTH(WIDTH)) u_core (
      .clk     (clk),
      .clear_n (clear_n),
      .nxt     (stage_d),
      .cur     (stage_q)
   );

   shreg4_outbuf #(.WIDTH(WIDTH), .HAS_TRISTATE(HAS_TRISTATE)) u_buf (
      .din (stage_q),
      .en  (out_ctrl),
      .pad (q_out)
   );

   assign q_data      = stage_q;
   assign q_oe        = out_ctrl;
   assign cascade_out = stage_q[LAST];
endmodule

// File: rtl/shreg4_bidir_chk.sv
module shreg4_bidir_chk #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             clear_n,
   input logic             load_shift,
   input logic             serial_in,
   input logic [WIDTH-1:0] par_in,
   input logic             out_ctrl,
   input logic [WIDTH-1:0] q_out,
   input logic [WIDTH-1:0] q_data,
   input logic             q_oe,
   input logic             cascade_out
);
   // R3: a load captures par_in on the falling edge
   p_load_r3: assert property (@(negedge clk) disable iff (!clear_n)
      load_shift |=> (q_data == $past(par_in)));

   // R4: a shift moves toward the last stage and takes serial_in at stage 0
   p_shift_r4: assert property (@(negedge clk) disable iff (!clear_n)
      !load_shift |=> (q_data == {$past(q_data[WIDTH-2:0]), $past(serial_in)}));

   // R5: after a load, the chaining output carries the top parallel bit
   p_cascade_r5: assert property (@(negedge clk) disable iff (!clear_n)
      load_shift |=> (cascade_out == $past(par_in[WIDTH-1])));

   // R6: when enabled, the pads carry the stage values
   p_pad_r6: assert property (@(negedge clk) disable iff (!clear_n)
      out_ctrl |-> (q_oe && (q_out == q_data)));

   // R2: clear holds everything at zero
   always @(negedge clk) begin
      if (!clear_n) begin
         p_clear_r2: assert (q_data == '0 && cascade_out == 1'b0);
      end
   end
endmodule

bind shreg4_bidir shreg4_bidir_chk #(.WIDTH(WIDTH)) u_chk (
   .clk         (clk),
   .clear_n     (clear_n),
   .load_shift  (load_shift),
   .serial_in   (serial_in),
   .par_in      (par_in),
   .out_ctrl    (out_ctrl),
   .q_out       (q_out),
   .q_data      (q_data),
   .q_oe        (q_oe),
   .cascade_out (cascade_out)
);

// File: tb/tb_shreg4_bidir.sv
`timescale 1ns/1ps
module tb_shreg4_bidir;
   localparam int W = 4;

   logic         clk = 1'b1;
   logic         clear_n;
   logic         load_shift;
   logic         serial_in;
   logic [W-1:0] par_in;
   logic         out_ctrl;
   logic [W-1:0] q_out;
   logic [W-1:0] q_data;
   logic         q_oe;
   logic         cascade_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   shreg4_bidir #(.WIDTH(W)) dut (
      .clk(clk), .clear_n(clear_n), .load_shift(load_shift),
      .serial_in(serial_in), .par_in(par_in), .out_ctrl(out_ctrl),
      .q_out(q_out), .q_data(q_data), .q_oe(q_oe), .cascade_out(cascade_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // vector fields: {load_shift, serial_in, out_ctrl, par_in[3:0], expected[3:0]}
   localparam int NV = 8;
   localparam logic [10:0] VEC [NV] = '{
      {1'b1, 1'b0, 1'b1, 4'b1010, 4'b1010},  // R3 load
      {1'b0, 1'b1, 1'b1, 4'b0000, 4'b0101},  // R4 shift in 1
      {1'b0, 1'b1, 1'b1, 4'b1111, 4'b1011},  // R4
      {1'b0, 1'b0, 1'b0, 4'b0000, 4'b0110},  // R7 shift, outputs off
      {1'b0, 1'b0, 1'b1, 4'b0000, 4'b1100},  // R4
      {1'b1, 1'b0, 1'b0, 4'b0111, 4'b0111},  // R7 load, outputs off
      {1'b0, 1'b1, 1'b0, 4'b0000, 4'b1111},  // R7 shift, outputs off
      {1'b1, 1'b1, 1'b1, 4'b0000, 4'b0000}   // R3 load zero
   };

   initial begin
      clear_n = 1'b0; load_shift = 1'b0; serial_in = 1'b0;
      par_in = '0; out_ctrl = 1'b1;
      #1;
      chk("R2 reset stages", q_data, 0);
      chk("R2 reset cascade", cascade_out, 0);
      @(posedge clk); #1;
      clear_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         load_shift = VEC[v][10];
         serial_in  = VEC[v][9];
         out_ctrl   = VEC[v][8];
         par_in     = VEC[v][7:4];
         @(negedge clk); #1;
         chk("R3/R4/R7 stages", q_data, VEC[v][3:0]);
         chk("R5 cascade", cascade_out, VEC[v][3]);
         chk("R6 q_oe", q_oe, VEC[v][8]);
         if (VEC[v][8]) chk("R6 q_out", q_out, VEC[v][3:0]);
      end

      // R1: no falling edge, no change
      out_ctrl = 1'b1;
      load_shift = 1'b1; par_in = 4'b1001;
      @(negedge clk); #1;
      chk("R3 load 1001", q_data, 4'b1001);
      par_in = 4'b0110; load_shift = 1'b0; serial_in = 1'b1;
      @(posedge clk); #1;
      chk("R1 hold across rising edge", q_data, 4'b1001);

      // R8: wired left move
      load_shift = 1'b1; par_in = {1'b0, q_data[W-1:1]};
      @(negedge clk); #1;
      chk("R8 left move D=0", q_data, 4'b0100);
      par_in = {1'b1, q_data[W-1:1]};
      @(negedge clk); #1;
      chk("R8 left move D=1", q_data, 4'b1010);
      chk("R5 cascade after left move", cascade_out, 1'b1);

      // R2: clear during a sequence, dominating a load request
      par_in = 4'b1111;
      @(negedge clk); #1;
      chk("R3 load 1111", q_data, 4'b1111);
      @(posedge clk); #1;
      clear_n = 1'b0;
      #0.5;
      chk("R2 async clear stages", q_data, 0);
      chk("R2 async clear cascade", cascade_out, 0);
      @(negedge clk); #1;
      chk("R2 clear dominates load", q_data, 0);

      // R9: first edge after release
      @(posedge clk); #1;
      clear_n = 1'b1; load_shift = 1'b1; par_in = 4'b0011;
      @(negedge clk); #1;
      chk("R9 first edge after clear", q_data, 4'b0011);
      load_shift = 1'b0; serial_in = 1'b1; out_ctrl = 1'b0;
      @(negedge clk); #1;
      chk("R7 shift while disabled", q_data, 4'b0111);
      chk("R6 q_oe low", q_oe, 1'b0);
      chk("R5 cascade while disabled", cascade_out, 1'b0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule